// File: doc/BRIEF.md
# Three-Row Neighbourhood Chunk Cache

This block sits between a single-pixel reader and a frame buffer whose read port returns a whole chunk of N pixels per address. The reader is typically a cellular-automaton kernel that visits the 3×3 neighbourhood of each cell. Such a kernel keeps returning to the same chunk column on three adjacent rows, so the block keeps three cached chunks. All three share one chunk-column tag, and each has its own row tag.

A request carries a pixel position (x, y) under a valid/ready handshake. On a hit, the addressed pixel comes back in the next cycle and the memory is not touched. On a miss, the block issues one chunk read, waits for the memory response and inserts the chunk as the newest entry. It then returns the pixel. A miss in a new chunk column first drops every row held for the old column. A flush input drops everything, for use when the display and render buffers swap.

Top module: `nbr_chunk_cache`

## Requirements
- R1: A request hits when x/N equals the shared column tag and y equals one entry's row tag. A hit is answered with rsp_valid high in the cycle after acceptance, and no memory read is issued.
- R2: At no time does more than one entry match a lookup.
- R3: A miss whose column x/N differs from the stored column invalidates all three row tags before the insert, so afterwards only the fetched row can hit.
- R4: On a miss the fetched row goes into the newest slot and the other entries each age by one slot. The entry that was oldest of the three is dropped, and it misses when requested again.
- R5: After reset the column tag holds FRAME_W and every row tag holds FRAME_H. Neither value is a legal position, so the first request always misses.
- R6: The returned pixel is bit (x mod N) of the chunk. Bit i of a chunk read from column c and row y is the pixel at (c·N+i, y).
- R7: For a request accepted as a miss, mem_req_valid is high for exactly one cycle, the cycle after acceptance, with mem_req_chunk = x/N and mem_req_row = y. The pixel is answered in the cycle after mem_rsp_valid.
- R8: req_ready is low from the cycle after a miss is accepted until the cycle after its memory response arrives. It is also low in any cycle with flush high.
- R9: After a flush cycle, no earlier content hits, and the next request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached entries |
| req_valid | input | 1 | Pixel request valid |
| req_ready | output | 1 | Block can accept a request |
| req_x | input | XW | Pixel column |
| req_y | input | YW | Pixel row |
| rsp_valid | output | 1 | Pixel response valid (one cycle) |
| rsp_pixel | output | 1 | Pixel value |
| mem_req_valid | output | 1 | Chunk read request |
| mem_req_chunk | output | XW | Chunk column index x/N |
| mem_req_row | output | YW | Row of the chunk read |
| mem_rsp_valid | input | 1 | Chunk read data valid |
| mem_rsp_data | input | CHUNK_W | Chunk pixels, bit i is offset i |

## Verification
The bench builds the block with N = 8, a frame 32 pixels wide and 16 rows high, and three entries. With a chunk this narrow, every offset in a chunk, including the top offset 7 at x = 31, can be swept in a few requests. With only four columns and sixteen rows, column changes, evictions and the out-of-range reset tags all come up within a short scripted walk. Each request states whether it should hit. The bench counts memory reads and checks each returned pixel against a pixel function that it computes itself.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ncc_state_e;

  // chunk column of a pixel column
  function automatic int chunk_of(int x, int ofs_w);
    return x >> ofs_w;
  endfunction

  // pixel offset inside its chunk
  function automatic int offset_of(int x, int ofs_w);
    return x & ((1 << ofs_w) - 1);
  endfunction

endpackage

// File: rtl/ncc_match.sv
module ncc_match #(
  parameter int ROWS = 3,
  parameter int XW   = 6,
  parameter int YW   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [XW-1:0]             tag_chunk,
  input  logic [ROWS-1:0][YW-1:0]   tag_rows,
  input  logic [XW-1:0]             q_chunk,
  input  logic [YW-1:0]             q_row,
  output logic [ROWS-1:0]           hit_vec,
  output logic                      hit
);

  logic col_eq;
  assign col_eq = (tag_chunk == q_chunk);

  for (genvar i = 0; i < ROWS; i++) begin : g_cmp
    assign hit_vec[i] = col_eq && (tag_rows[i] == q_row);
  end

  assign hit = |hit_vec;

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/ncc_lines.sv
module ncc_lines #(
  parameter int ROWS  = 3,
  parameter int CW    = 16,
  parameter int XW    = 6,
  parameter int YW    = 5,
  parameter int X_INV = 64,
  parameter int Y_INV = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      ins,
  input  logic [XW-1:0]             ins_chunk,
  input  logic [YW-1:0]             ins_row,
  input  logic [CW-1:0]             ins_data,
  output logic [XW-1:0]             tag_chunk,
  output logic [ROWS-1:0][YW-1:0]   tag_rows,
  output logic [ROWS-1:0][CW-1:0]   lines
);

  localparam logic [XW-1:0] XI = XW'(X_INV);
  localparam logic [YW-1:0] YI = YW'(Y_INV);

  logic col_change;
  assign col_change = ins && (ins_chunk != tag_chunk);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      tag_chunk <= XI;
    end else if (ins) begin
      tag_chunk <= ins_chunk;
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        tag_rows[i] <= YI;
      end else if (ins) begin
        if (i == 0) tag_rows[i] <= ins_row;
        else        tag_rows[i] <= col_change ? YI : tag_rows[(i == 0) ? 0 : i - 1];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lines[i] <= '0;
      end else if (ins && !flush) begin
        if (i == 0) lines[i] <= ins_data;
        else        lines[i] <= lines[(i == 0) ? 0 : i - 1];
      end
    end
  end

  // R3
  col_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_change && !flush) |=> (tag_rows[ROWS-1] == YI && tag_rows[1] == YI));

  // R4
  newest_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && !flush) |=> (tag_rows[0] == $past(ins_row) && lines[0] == $past(ins_data)));

  // R4
  age_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && !flush && !col_change) |=> (tag_rows[1] == $past(tag_rows[0])));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tag_chunk == XI && tag_rows[0] == YI && tag_rows[ROWS-1] == YI));

endmodule

// File: rtl/ncc_ctrl.sv
module ncc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic req_valid,
  input  logic lookup_hit,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic acc_hit,
  output logic acc_miss,
  output logic mem_req_valid,
  output logic fill,
  output logic rsp_valid
);
  import ncc_pkg::*;

  ncc_state_e state, state_nx;

  assign req_ready     = (state == ST_IDLE) && !flush;
  assign acc_hit       = req_valid && req_ready && lookup_hit;
  assign acc_miss      = req_valid && req_ready && !lookup_hit;
  assign mem_req_valid = (state == ST_ISSUE);
  assign fill          = (state == ST_WAIT) && mem_rsp_valid;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (acc_miss) state_nx = ST_ISSUE;
      ST_ISSUE: state_nx = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      state     <= state_nx;
      rsp_valid <= acc_hit || fill;
    end
  end

  // R1
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (rsp_valid && !mem_req_valid));

  // R7
  miss_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> mem_req_valid);

  // R7
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R7
  fill_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> rsp_valid);

  // R8
  miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> !req_ready);

endmodule

// File: rtl/nbr_chunk_cache.sv
module nbr_chunk_cache #(
  parameter int CHUNK_W = 16,
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 32,
  parameter int ROWS    = 3,
  parameter int XW      = $clog2(FRAME_W + 1),
  parameter int YW      = $clog2(FRAME_H + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [XW-1:0]      req_x,
  input  logic [YW-1:0]      req_y,
  output logic               rsp_valid,
  output logic               rsp_pixel,
  output logic               mem_req_valid,
  output logic [XW-1:0]      mem_req_chunk,
  output logic [YW-1:0]      mem_req_row,
  input  logic               mem_rsp_valid,
  input  logic [CHUNK_W-1:0] mem_rsp_data
);
  import ncc_pkg::*;

  localparam int OFS_W = $clog2(CHUNK_W);

  // named internal events
  logic                        acc_hit, acc_miss, fill, lookup_hit;
  logic [ROWS-1:0]             hit_vec;
  logic [XW-1:0]               tag_chunk, q_chunk, pend_chunk;
  logic [ROWS-1:0][YW-1:0]     tag_rows;
  logic [ROWS-1:0][CHUNK_W-1:0] lines;
  logic [OFS_W-1:0]            q_ofs, pend_ofs;
  logic [XW-1:0]               pend_x;
  logic [YW-1:0]               pend_y;
  logic [CHUNK_W-1:0]          hit_line;

  assign q_chunk    = XW'(chunk_of(int'(req_x), OFS_W));
  assign q_ofs      = OFS_W'(offset_of(int'(req_x), OFS_W));
  assign pend_chunk = XW'(chunk_of(int'(pend_x), OFS_W));
  assign pend_ofs   = OFS_W'(offset_of(int'(pend_x), OFS_W));

  ncc_match #(.ROWS(ROWS), .XW(XW), .YW(YW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .tag_chunk (tag_chunk),
    .tag_rows  (tag_rows),
    .q_chunk   (q_chunk),
    .q_row     (req_y),
    .hit_vec   (hit_vec),
    .hit       (lookup_hit)
  );

  ncc_lines #(.ROWS(ROWS), .CW(CHUNK_W), .XW(XW), .YW(YW),
              .X_INV(FRAME_W), .Y_INV(FRAME_H)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .ins       (fill),
    .ins_chunk (pend_chunk),
    .ins_row   (pend_y),
    .ins_data  (mem_rsp_data),
    .tag_chunk (tag_chunk),
    .tag_rows  (tag_rows),
    .lines     (lines)
  );

  ncc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .lookup_hit    (lookup_hit),
    .mem_rsp_valid (mem_rsp_valid),
    .req_ready     (req_ready),
    .acc_hit       (acc_hit),
    .acc_miss      (acc_miss),
    .mem_req_valid (mem_req_valid),
    .fill          (fill),
    .rsp_valid     (rsp_valid)
  );

  always_comb begin
    hit_line = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (hit_vec[i]) hit_line = hit_line | lines[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_x    <= '0;
      pend_y    <= '0;
      rsp_pixel <= 1'b0;
    end else begin
      if (acc_miss) begin
        pend_x <= req_x;
        pend_y <= req_y;
      end
      if (acc_hit)   rsp_pixel <= hit_line[q_ofs];
      else if (fill) rsp_pixel <= mem_rsp_data[pend_ofs];
    end
  end

  assign mem_req_chunk = pend_chunk;
  assign mem_req_row   = pend_y;

  // R6
  fill_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (rsp_pixel == $past(mem_rsp_data[pend_ofs])));

  // R7
  issue_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> (mem_req_row == $past(req_y) && mem_req_chunk == $past(q_chunk)));

endmodule

// File: tb/sim_nbr_chunk_cache.sv
module sim_nbr_chunk_cache;
  localparam int CW = 8, FW = 32, FH = 16;
  localparam int XW = $clog2(FW + 1), YW = $clog2(FH + 1);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, req_valid = 1'b0;
  logic req_ready, rsp_valid, rsp_pixel, mem_req_valid;
  logic [XW-1:0] req_x = '0, mem_req_chunk;
  logic [YW-1:0] req_y = '0, mem_req_row;
  logic mem_rsp_valid = 1'b0;
  logic [CW-1:0] mem_rsp_data = '0;

  int checks = 0, errors = 0, fetches = 0;
  int exp_chunk = 0, exp_row = 0;
  bit exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  nbr_chunk_cache #(.CHUNK_W(CW), .FRAME_W(FW), .FRAME_H(FH), .ROWS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_x(req_x), .req_y(req_y),
    .rsp_valid(rsp_valid), .rsp_pixel(rsp_pixel),
    .mem_req_valid(mem_req_valid), .mem_req_chunk(mem_req_chunk),
    .mem_req_row(mem_req_row), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  function automatic bit pix(int x, int y);
    int v;
    v = x * 5 + y * 11 + (x & y);
    return ^v[7:0];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: answers two cycles after a request
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rst_n && mem_req_valid) begin
        fetches++;
        chk(int'(mem_req_chunk) == exp_chunk, "R7 chunk", int'(mem_req_chunk), exp_chunk);
        chk(int'(mem_req_row) == exp_row, "R7 row", int'(mem_req_row), exp_row);
        @(negedge clk);
        chk(!mem_req_valid, "R7 pulse", int'(mem_req_valid), 0);
        @(negedge clk);
        for (int i = 0; i < CW; i++) mem_rsp_data[i] = pix(exp_chunk * CW + i, exp_row);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1 unexpected response", 1, 0);
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_pixel == e, t, int'(rsp_pixel), int'(e));
        end
      end
    end
  end

  task automatic send(int x, int y, bit exp_hit, string tag);
    int f0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready when idle", int'(req_ready), 1);
    f0 = fetches;
    exp_chunk = x / CW;
    exp_row = y;
    req_valid = 1'b1;
    req_x = XW'(x);
    req_y = YW'(y);
    exp_q.push_back(pix(x, y));
    tag_q.push_back({"R6 pixel ", tag});
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk(rsp_valid == 1'b1, {"R1 hit latency ", tag}, int'(rsp_valid), 1);
    end else begin
      chk(req_ready == 1'b0, {"R8 busy on miss ", tag}, int'(req_ready), 0);
      for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
      chk(rsp_valid == 1'b1, {"R7 answer after fill ", tag}, int'(rsp_valid), 1);
    end
    chk(fetches - f0 == (exp_hit ? 0 : 1), {"fetch count ", tag}, fetches - f0, exp_hit ? 0 : 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(req_ready == 1'b1, "R5 reset ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R5 reset rsp", int'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R5 reset mem", int'(mem_req_valid), 0);

    send(0, 0, 0, "R5 first miss");
    send(1, 0, 1, "R1 same chunk");
    send(7, 0, 1, "R6 top offset");
    send(5, 1, 0, "R4 fill row1");
    send(5, 2, 0, "R4 fill row2");
    send(3, 0, 1, "R2 oldest row");
    send(3, 1, 1, "R2 middle row");
    send(3, 2, 1, "R2 newest row");
    send(4, 3, 0, "R4 evict row0");
    send(2, 0, 0, "R4 evicted misses");
    send(2, 2, 1, "R4 survivor");
    send(2, 1, 0, "R4 row1 evicted");
    send(6, 3, 1, "R4 row3 kept");
    send(6, 2, 0, "R4 row2 evicted");
    send(9, 1, 0, "R3 new column");
    send(3, 0, 0, "R3 old column gone");
    send(1, 1, 0, "R3 rows cleared");
    send(10, 1, 0, "R3 column back");
    send(15, 1, 1, "R6 chunk1 top");
    @(negedge clk);
    flush = 1'b1;
    #1 chk(req_ready == 1'b0, "R8 flush blocks", int'(req_ready), 0);
    @(negedge clk);
    flush = 1'b0;
    send(12, 1, 0, "R9 after flush");
    send(31, 15, 0, "R6 last pixel");
    for (int x = 24; x < 31; x++) send(x, 15, 1, "R6 sweep");
    send(31, 14, 0, "R4 row14");
    send(31, 13, 0, "R4 row13");
    send(24, 15, 1, "R4 three rows held");
    send(24, 12, 0, "R4 evict row15");
    send(30, 15, 0, "R4 row15 gone");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all answered", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule